// File: doc/BRIEF.md
# RTC Status and Alarm Flag Register

This block is the byte-wide status register of a real-time clock. It sits on a simple register bus with an address, a write enable, write data and read data. It keeps three sticky event flags:

- an oscillator-stop flag;
- two alarm-match flags.

It also keeps an enable for the 32.768 kHz square-wave output and a busy indicator for temperature-compensation activity. Events come from neighbouring logic as single-cycle pulses. The neighbouring logic includes the oscillator monitor, the alarm comparators and the compensation engine.

Software reads the register to learn which events happened. It clears an event by writing 0 to its flag. Writing 1 to a flag never sets it, so a read-modify-write cannot lose an event that arrives in between.

The alarm flags are combined with per-alarm interrupt enables and an interrupt-mode select. The result drives a registered, active-low interrupt output.

Top module: `rtc_status_reg`

## Requirements
- R1: After reset, the register reads 0x88, which is the oscillator-stop flag and the 32 kHz enable set and all else clear. `irq_n` is 1.
- R2: The read data at the register address STATUS_ADDR (default 0xF) is {osc-stop flag (bit 7), 0, 0, 0, 32 kHz enable (bit 3), busy (bit 2), alarm-2 flag (bit 1), alarm-1 flag (bit 0)}. Any other address reads 0x00.
- R3: A pulse on `osc_stop_evt`, `alarm1_hit` or `alarm2_hit` sets bit 7, bit 0 or bit 1 respectively on the next clock edge.
- R4: A write to STATUS_ADDR with 0 in bit 7, 1 or 0 clears that flag. A write with 1 in the same bit leaves the flag unchanged.
- R5: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R6: Bit 3 (the 32 kHz enable) is read/write. `clk32_oe` is 1 exactly when bit 3 is 1 and `osc_run` is 1.
- R7: Bit 2 (busy) is set by `conv_start` and cleared by `comp_idle`, with `conv_start` taking priority. Writes to bit 2 are ignored.
- R8: `irq_n` goes low one cycle after `int_mode`=1 and (alarm-1 flag and `alm1_ie`, or alarm-2 flag and `alm2_ie`) becomes true. It goes high one cycle after that condition becomes false.
- R9: Bits 6..4 always read 0, whatever is written. Writes with `bus_addr` not equal to STATUS_ADDR change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| osc_stop_evt | input | 1 | Oscillator-stop event pulse |
| alarm1_hit | input | 1 | Alarm 1 match pulse |
| alarm2_hit | input | 1 | Alarm 2 match pulse |
| conv_start | input | 1 | Temperature conversion request |
| comp_idle | input | 1 | Compensation engine entered idle |
| osc_run | input | 1 | Oscillator running |
| alm1_ie | input | 1 | Alarm 1 interrupt enable |
| alm2_ie | input | 1 | Alarm 2 interrupt enable |
| int_mode | input | 1 | 1 = pin acts as alarm interrupt |
| clk32_oe | output | 1 | 32 kHz output enable (0 = high impedance) |
| irq_n | output | 1 | Active-low registered interrupt |

## Verification
A flag stuck at 0, or one set by a written 1, shows at `bus_rdata` in the first read after the offending edge. The same error shows at `irq_n` one cycle later when that alarm's enables are on. A lost set/clear priority shows only in the cycle where a pulse meets a write, so the bench aims pulses at clearing writes on purpose. A wrong busy or enable bit shows at once on the read data and, for the enable, on `clk32_oe`.

// File: rtl/rtc_status_reg.sv
module rtc_status_reg #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              osc_stop_evt,
  input  logic              alarm1_hit,
  input  logic              alarm2_hit,
  input  logic              conv_start,
  input  logic              comp_idle,
  input  logic              osc_run,
  input  logic              alm1_ie,
  input  logic              alm2_ie,
  input  logic              int_mode,
  output logic              clk32_oe,
  output logic              irq_n
);

  logic osf, en32, busy, a2f, a1f;
  logic sel, wr_hit, irq_want;

  assign sel    = (bus_addr == STATUS_ADDR);
  assign wr_hit = bus_we & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osf  <= 1'b1;
      en32 <= 1'b1;
      busy <= 1'b0;
      a2f  <= 1'b0;
      a1f  <= 1'b0;
    end else begin
      osf  <= osc_stop_evt | (osf & ~(wr_hit & ~bus_wdata[7]));
      a2f  <= alarm2_hit   | (a2f & ~(wr_hit & ~bus_wdata[1]));
      a1f  <= alarm1_hit   | (a1f & ~(wr_hit & ~bus_wdata[0]));
      if (wr_hit) en32 <= bus_wdata[3];
      if (conv_start)     busy <= 1'b1;
      else if (comp_idle) busy <= 1'b0;
    end
  end

  assign irq_want = int_mode & ((a1f & alm1_ie) | (a2f & alm2_ie));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~irq_want;
  end

  assign clk32_oe  = en32 & osc_run;
  assign bus_rdata = sel ? {osf, 3'b000, en32, busy, a2f, a1f} : 8'h00;

  // R3
  a1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm1_hit |=> a1f);
  // R4
  a1_no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a1f && !alarm1_hit) |=> !a1f);
  // R4
  osf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osf && !(bus_we && bus_addr == STATUS_ADDR && !bus_wdata[7])) |=> osf);
  // R6
  en32_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == STATUS_ADDR) |=> (en32 == $past(bus_wdata[3])));
  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);
  // R7
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_idle && !conv_start) |=> !busy);
  // R8
  irq_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |=> irq_n);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(a1f | a2f));
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[6:4] == 3'b000);

endmodule

// File: tb/sim_rtc_status_reg.sv
module sim_rtc_status_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = 4'hF;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic osc_stop_evt = 0, alarm1_hit = 0, alarm2_hit = 0;
  logic conv_start = 0, comp_idle = 0, osc_run = 1;
  logic alm1_ie = 0, alm2_ie = 0, int_mode = 0;
  wire [7:0] bus_rdata;
  wire clk32_oe, irq_n;

  int errors = 0, checks = 0;
  logic m_osf, m_en, m_busy, m_a2, m_a1, m_irqn;

  always #5 clk = ~clk;

  rtc_status_reg u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_stop_evt(osc_stop_evt),
    .alarm1_hit(alarm1_hit), .alarm2_hit(alarm2_hit), .conv_start(conv_start),
    .comp_idle(comp_idle), .osc_run(osc_run), .alm1_ie(alm1_ie), .alm2_ie(alm2_ie),
    .int_mode(int_mode), .clk32_oe(clk32_oe), .irq_n(irq_n));

  function automatic logic [7:0] exp_rd();
    return (bus_addr == 4'hF) ? {m_osf, 3'b000, m_en, m_busy, m_a2, m_a1} : 8'h00;
  endfunction

  function automatic logic flag_next(logic cur, logic evt, logic wbit);
    logic clr = bus_we && bus_addr == 4'hF && !wbit;
    return evt | (cur & ~clr);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_osf = 1; m_en = 1; m_busy = 0; m_a2 = 0; m_a1 = 0; m_irqn = 1;
  endtask

  // inputs already driven; check then advance one clock
  task automatic step(input string req);
    logic n_osf, n_en, n_busy, n_a2, n_a1, n_irqn;
    #1;
    check(bus_rdata == exp_rd(), req, bus_rdata, exp_rd());
    check(irq_n == m_irqn, "R8", irq_n, m_irqn);
    check(clk32_oe == (m_en & osc_run), "R6", clk32_oe, m_en & osc_run);
    n_osf  = flag_next(m_osf, osc_stop_evt, bus_wdata[7]);
    n_a2   = flag_next(m_a2, alarm2_hit, bus_wdata[1]);
    n_a1   = flag_next(m_a1, alarm1_hit, bus_wdata[0]);
    n_en   = (bus_we && bus_addr == 4'hF) ? bus_wdata[3] : m_en;
    n_busy = conv_start ? 1'b1 : (comp_idle ? 1'b0 : m_busy);
    n_irqn = ~(int_mode & ((m_a1 & alm1_ie) | (m_a2 & alm2_ie)));
    @(negedge clk);
    m_osf = n_osf; m_a2 = n_a2; m_a1 = n_a1; m_en = n_en; m_busy = n_busy; m_irqn = n_irqn;
  endtask

  task automatic idle_in();
    bus_we = 0; osc_stop_evt = 0; alarm1_hit = 0; alarm2_hit = 0;
    conv_start = 0; comp_idle = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(bus_rdata == 8'h88, "R1", bus_rdata, 8'h88);
    check(irq_n == 1'b1, "R1", irq_n, 1);
    step("R1");
    bus_addr = 4'h3; step("R2");
    bus_we = 1; bus_wdata = 8'h55; step("R9");
    idle_in(); bus_addr = 4'hF; step("R9");
    bus_we = 1; bus_wdata = 8'hFF; step("R4");
    idle_in(); step("R9");
    bus_we = 1; bus_wdata = 8'h00; step("R4");
    idle_in(); step("R6");
    osc_run = 0; step("R6"); osc_run = 1;
    alarm1_hit = 1; step("R3");
    alarm1_hit = 0; alarm2_hit = 1; osc_stop_evt = 1; step("R3");
    idle_in(); step("R3");
    bus_we = 1; bus_wdata = 8'h00; alarm1_hit = 1; step("R5");
    idle_in(); step("R5");
    int_mode = 1; alm1_ie = 1; step("R8");
    step("R8");
    alm1_ie = 0; step("R8");
    step("R8");
    conv_start = 1; step("R7");
    conv_start = 0; bus_we = 1; bus_wdata = 8'h08; step("R7");
    bus_we = 0; conv_start = 1; comp_idle = 1; step("R7");
    conv_start = 0; step("R7");
    idle_in(); step("R7");
    for (int i = 0; i < 3000; i++) begin
      bus_addr     = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      bus_we       = ($urandom % 5 == 0);
      bus_wdata    = 8'($urandom);
      osc_stop_evt = ($urandom % 23 == 0);
      alarm1_hit   = ($urandom % 9 == 0);
      alarm2_hit   = ($urandom % 11 == 0);
      conv_start   = ($urandom % 13 == 0);
      comp_idle    = ($urandom % 7 == 0);
      osc_run      = ($urandom % 8 != 0);
      alm1_ie      = $urandom;
      alm2_ie      = $urandom;
      int_mode     = ($urandom % 4 != 0);
      step("R3");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule